// File: doc/BRIEF.md
# Composite Monochrome Video Raster Timing Generator

This block produces the raster timing for a monochrome composite video display of roughly 256 by 200 pixels. It has three outputs. The first is an active-low sync output. The second is a grey-level pixel bus of 1, 2 or 4 bits. The third is a one-cycle pulse that marks the end of the visible picture, so that software can swap its drawing and display buffers during vertical blanking. An external resistor network mixes the sync line and the pixel lines into one analogue voltage. Sync is the lowest level, black is a little above it and white is the highest, so the pixel bus must read zero whenever sync is asserted.

The line timebase and the pixel timebase share one clock. A line counter drives sync. A divider inside the visible window makes the pixel strobe. Pixels arrive as packed words on a valid/ready stream, most significant pixel first, and a word is requested only at the start of each group of pixels inside the visible window. If no word is offered when one is requested, that whole group is shown black. All spans are cycle-count parameters, with defaults derived from the clock frequency. The delay between the end of horizontal sync and the first pixel comes from an input. That input is taken at each line boundary and clamped so that the window always fits in the line.

Top module: `ntsc_raster_gen`

## Requirements
- R1: While reset is held, sync_n_o is 1, pix_o is 0, frame_done_o is 0 and pix_ready_o is 0.
- R2: The line position starts at 0 in the first cycle after reset is released and wraps after LINE_CYC cycles. The registered outputs show the position of the previous cycle. On lines that are not vertical-sync lines, sync_n_o is 0 for the first HSYNC_CYC positions of the line.
- R3: Lines 0 to VS_LINES-1 of each frame of FRAME_LINES lines are vertical-sync lines. On these lines sync_n_o is 0 for the first LINE_CYC-HSYNC_CYC positions, which forms the long frame-sync pulse.
- R4: The visible window covers lines VACT_START to VACT_START+ACT_LINES-1. On each of these lines it starts at position HSYNC_CYC+P and lasts PIX_PER_LINE*PIX_DIV positions. P is porch_i sampled at the last position of the previous line and clamped to LINE_CYC-HSYNC_CYC-PIX_PER_LINE*PIX_DIV-1. P is BP_RST after reset.
- R5: pix_ready_o is high only inside the window, and only in the first cycle of the first pixel of each group of WORD_W/BPP pixels.
- R6: A word accepted with pix_valid_i and pix_ready_o both high is shown starting with bits [WORD_W-1 -: BPP]. Each following pixel comes from the next BPP bits down. Each pixel is held for PIX_DIV cycles, and the first pixel appears one cycle after the accepting edge.
- R7: If pix_valid_i is low when pix_ready_o is high, pix_o is 0 for all pixels of that group.
- R8: pix_o is 0 outside the window, and is always 0 while sync_n_o is 0.
- R9: frame_done_o pulses high for exactly one cycle per frame. The pulse comes in the cycle where pix_o returns to black after the last pixel of the last visible line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all timing |
| rst_n | input | 1 | Synchronous active-low reset |
| porch_i | input | PORCH_W | Delay, in cycles, from the end of horizontal sync to the first pixel |
| pix_valid_i | input | 1 | A pixel word is offered |
| pix_word_i | input | WORD_W | Packed pixels, most significant pixel first |
| pix_ready_o | output | 1 | A pixel word is taken at this edge if one is offered |
| sync_n_o | output | 1 | Sync to the DAC, 0 = sync level |
| pix_o | output | BPP | Grey level to the DAC, 0 = black |
| frame_done_o | output | 1 | One-cycle pulse after the last visible pixel of a frame |

## Verification
The assertions check on every cycle the properties that hold at any moment. Pixels are black during sync. A request is followed by a cycle outside sync. Requests are never back to back. An unanswered request blanks the next pixel. The frame pulse lasts one cycle and falls on a black pixel. The exact lengths of the line sync and the frame sync, the window position under porch values inside and beyond the clamp limit, the order of pixels within a word, blanking of whole groups after an underrun, and one frame pulse per frame can only be shown by the bench scenarios. Those scenarios compare every output each cycle against a timing model built from the requirements.

// File: rtl/ntsc_pkg.sv
// Shared types for the raster timing generator.
package ntsc_pkg;

    // Kind of the current scan line within a frame.
    typedef enum logic [1:0] {
        LN_VSYNC  = 2'd0,
        LN_BLANK  = 2'd1,
        LN_ACTIVE = 2'd2
    } line_kind_e;

endpackage

// File: rtl/ntsc_frame_seq.sv
// Frame sequencer: counts scan lines and classifies each one.
// Assumes: line_end_i is high for exactly one cycle per line, and the
// vertical-sync lines come before the visible lines.
module ntsc_frame_seq
    import ntsc_pkg::*;
#(
    parameter int FRAME_LINES = 262,
    parameter int VS_LINES    = 3,
    parameter int VACT_START  = 20,
    parameter int ACT_LINES   = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_end_i,
    output line_kind_e kind_o,
    output logic       last_active_o
);
    localparam int VW = $clog2(FRAME_LINES + 1);
    localparam logic [VW-1:0] V_LAST     = VW'(FRAME_LINES - 1);
    localparam logic [VW-1:0] V_VS_END   = VW'(VS_LINES);
    localparam logic [VW-1:0] V_ACT_FST  = VW'(VACT_START);
    localparam logic [VW-1:0] V_ACT_END  = VW'(VACT_START + ACT_LINES);
    localparam logic [VW-1:0] V_ACT_LAST = VW'(VACT_START + ACT_LINES - 1);

    generate
        if (VACT_START < VS_LINES || VACT_START + ACT_LINES > FRAME_LINES) begin : g_bad_lines
            $error("visible lines must follow vertical sync and fit in the frame");
        end
    endgenerate

    logic [VW-1:0] vcnt_q;

    // Advance the line index at each line boundary, wrapping at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt_q <= '0;
        end else if (line_end_i) begin
            vcnt_q <= (vcnt_q == V_LAST) ? '0 : vcnt_q + 1'b1;
        end
    end

    // Classify the current line.
    always_comb begin
        if (vcnt_q < V_VS_END) begin
            kind_o = LN_VSYNC;
        end else if (vcnt_q >= V_ACT_FST && vcnt_q < V_ACT_END) begin
            kind_o = LN_ACTIVE;
        end else begin
            kind_o = LN_BLANK;
        end
        last_active_o = (vcnt_q == V_ACT_LAST);
    end

endmodule

// File: rtl/ntsc_line_timer.sv
// Line timer: position within a scan line, sync decode and window bounds.
// Assumes: the porch limit is not negative, PORCH_W <= 32.
module ntsc_line_timer
    import ntsc_pkg::*;
#(
    parameter int LINE_CYC  = 15887,
    parameter int HSYNC_CYC = 1175,
    parameter int WIN_CYC   = 12800,
    parameter int PORCH_W   = 16,
    parameter int BP_RST    = 375
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PORCH_W-1:0] porch_i,
    input  line_kind_e         kind_i,
    output logic               line_end_o,
    output logic               sync_o,
    output logic               in_win_o,
    output logic               win_stop_o
);
    localparam int MAX_PORCH = LINE_CYC - HSYNC_CYC - WIN_CYC - 1;
    localparam int HW        = $clog2(LINE_CYC + 1);
    localparam logic [HW-1:0] H_LAST   = HW'(LINE_CYC - 1);
    localparam logic [HW-1:0] H_HS_END = HW'(HSYNC_CYC);
    localparam logic [HW-1:0] H_VS_END = HW'(LINE_CYC - HSYNC_CYC);
    localparam logic [HW-1:0] H_WIN    = HW'(WIN_CYC);

    generate
        if (MAX_PORCH < 0) begin : g_bad_line
            $error("window and sync do not fit in one line");
        end
    endgenerate

    // Limit a requested porch so the window ends before the line does.
    function automatic logic [HW-1:0] clamp_porch(input logic [PORCH_W-1:0] p);
        if (32'(p) > MAX_PORCH) begin
            return HW'(MAX_PORCH);
        end
        return HW'(p);
    endfunction

    localparam logic [PORCH_W-1:0] BP_RST_V = PORCH_W'(BP_RST);

    logic [HW-1:0] hcnt_q;
    logic [HW-1:0] porch_q;
    logic [HW-1:0] win_first;
    logic [HW-1:0] win_after;

    // Count positions within the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt_q <= '0;
        end else begin
            hcnt_q <= (hcnt_q == H_LAST) ? '0 : hcnt_q + 1'b1;
        end
    end

    // Take the porch request at the last position of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            porch_q <= clamp_porch(BP_RST_V);
        end else if (hcnt_q == H_LAST) begin
            porch_q <= clamp_porch(porch_i);
        end
    end

    // Decode line end, sync and the window bounds from the position.
    always_comb begin
        win_first  = H_HS_END + porch_q;
        win_after  = win_first + H_WIN;
        line_end_o = (hcnt_q == H_LAST);
        sync_o     = (kind_i == LN_VSYNC) ? (hcnt_q < H_VS_END) : (hcnt_q < H_HS_END);
        in_win_o   = (hcnt_q >= win_first) && (hcnt_q < win_after);
        win_stop_o = (hcnt_q == win_after);
    end

endmodule

// File: rtl/ntsc_pixel_shift.sv
// Pixel shifter: makes the pixel strobe inside the window, requests packed
// words, and shifts pixels out most significant first. Shows black on underrun.
// Assumes: win_i is low in the cycle before each window starts.
module ntsc_pixel_shift #(
    parameter int BPP     = 4,
    parameter int WORD_W  = 32,
    parameter int PIX_DIV = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_i,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              ready_o,
    output logic [BPP-1:0]    pix_o
);
    localparam int PPW = WORD_W / BPP;
    localparam int DW  = (PIX_DIV > 1) ? $clog2(PIX_DIV) : 1;
    localparam int SW  = (PPW > 1) ? $clog2(PPW) : 1;
    localparam logic [DW-1:0] D_LAST = DW'(PIX_DIV - 1);
    localparam logic [SW-1:0] S_LAST = SW'(PPW - 1);

    generate
        if (!(BPP == 1 || BPP == 2 || BPP == 4)) begin : g_bad_bpp
            $error("pixel depth must be 1, 2 or 4 bits");
        end
        if (WORD_W % BPP != 0) begin : g_bad_word
            $error("word width must hold a whole number of pixels");
        end
    endgenerate

    logic [DW-1:0]     div_q;
    logic [SW-1:0]     slot_q;
    logic [WORD_W-1:0] shreg_q;
    logic [BPP-1:0]    pix_q;
    logic              strobe;

    // The strobe marks the first cycle of each pixel; a word is requested at group start.
    always_comb begin
        strobe  = win_i && (div_q == '0);
        ready_o = strobe && (slot_q == '0);
        pix_o   = pix_q;
    end

    // Divide the clock into pixel periods, restarting with each window.
    always_ff @(posedge clk) begin
        if (!rst_n || !win_i) begin
            div_q <= '0;
        end else begin
            div_q <= (div_q == D_LAST) ? '0 : div_q + 1'b1;
        end
    end

    // Track which pixel of the current word is being shown.
    always_ff @(posedge clk) begin
        if (!rst_n || !win_i) begin
            slot_q <= '0;
        end else if (strobe) begin
            slot_q <= (slot_q == S_LAST) ? '0 : slot_q + 1'b1;
        end
    end

    // Load or shift the pixel word and drive the grey level; black outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !win_i) begin
            shreg_q <= '0;
            pix_q   <= '0;
        end else if (strobe) begin
            if (slot_q == '0) begin
                if (valid_i) begin
                    pix_q   <= word_i[WORD_W-1 -: BPP];
                    shreg_q <= word_i << BPP;
                end else begin
                    pix_q   <= '0;
                    shreg_q <= '0;
                end
            end else begin
                pix_q   <= shreg_q[WORD_W-1 -: BPP];
                shreg_q <= shreg_q << BPP;
            end
        end
    end

endmodule

// File: rtl/ntsc_raster_gen.sv
// Raster timing generator top: combines line timing, frame sequencing and
// the pixel shifter, and registers sync and the frame-done pulse.
// Assumes: one clock; the defaults give real line timing at CLK_MHZ.
module ntsc_raster_gen
    import ntsc_pkg::*;
#(
    parameter int CLK_MHZ      = 250,
    parameter int LINE_CYC     = CLK_MHZ * 6355 / 100,
    parameter int HSYNC_CYC    = CLK_MHZ * 47 / 10,
    parameter int PIX_DIV      = CLK_MHZ / 5,
    parameter int PIX_PER_LINE = 256,
    parameter int BPP          = 4,
    parameter int WORD_W       = 32,
    parameter int FRAME_LINES  = 262,
    parameter int VS_LINES     = 3,
    parameter int VACT_START   = 20,
    parameter int ACT_LINES    = 200,
    parameter int PORCH_W      = 16,
    parameter int BP_RST       = CLK_MHZ * 15 / 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PORCH_W-1:0] porch_i,
    input  logic               pix_valid_i,
    input  logic [WORD_W-1:0]  pix_word_i,
    output logic               pix_ready_o,
    output logic               sync_n_o,
    output logic [BPP-1:0]     pix_o,
    output logic               frame_done_o
);
    localparam int WIN_CYC = PIX_PER_LINE * PIX_DIV;

    generate
        if (PIX_PER_LINE % (WORD_W / BPP) != 0) begin : g_bad_groups
            $error("pixels per line must be a whole number of words");
        end
    endgenerate

    line_kind_e kind;
    logic       last_active;
    logic       line_end;
    logic       sync_raw;
    logic       win_raw;
    logic       win_stop;
    logic       win;
    logic       sync_n_q;
    logic       done_q;

    ntsc_frame_seq #(
        .FRAME_LINES (FRAME_LINES),
        .VS_LINES    (VS_LINES),
        .VACT_START  (VACT_START),
        .ACT_LINES   (ACT_LINES)
    ) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_end_i    (line_end),
        .kind_o        (kind),
        .last_active_o (last_active)
    );

    ntsc_line_timer #(
        .LINE_CYC  (LINE_CYC),
        .HSYNC_CYC (HSYNC_CYC),
        .WIN_CYC   (WIN_CYC),
        .PORCH_W   (PORCH_W),
        .BP_RST    (BP_RST)
    ) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .porch_i    (porch_i),
        .kind_i     (kind),
        .line_end_o (line_end),
        .sync_o     (sync_raw),
        .in_win_o   (win_raw),
        .win_stop_o (win_stop)
    );

    // The window is open only on visible lines.
    assign win = win_raw && (kind == LN_ACTIVE);

    ntsc_pixel_shift #(
        .BPP     (BPP),
        .WORD_W  (WORD_W),
        .PIX_DIV (PIX_DIV)
    ) u_pix (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_i   (win),
        .valid_i (pix_valid_i),
        .word_i  (pix_word_i),
        .ready_o (pix_ready_o),
        .pix_o   (pix_o)
    );

    // Register sync and frame-done so they line up with the pixel register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_n_q <= 1'b1;
            done_q   <= 1'b0;
        end else begin
            sync_n_q <= !sync_raw;
            done_q   <= (kind == LN_ACTIVE) && last_active && win_stop;
        end
    end

    assign sync_n_o     = sync_n_q;
    assign frame_done_o = done_q;

endmodule

// File: rtl/ntsc_raster_gen_chk.sv
// Checker for the raster timing generator, attached by bind.
module ntsc_raster_gen_chk #(
    parameter int BPP = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sync_n_o,
    input logic [BPP-1:0] pix_o,
    input logic           pix_ready_o,
    input logic           pix_valid_i,
    input logic           frame_done_o
);
    // R8: the pixel bus is black during sync.
    assert_black_in_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n_o |-> pix_o == '0);

    // R5: a request is followed by a cycle outside sync.
    assert_ready_after_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready_o |=> sync_n_o);

    // R5: requests never come in consecutive cycles.
    assert_ready_spaced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready_o |=> !pix_ready_o);

    // R7: an unanswered request shows black on the next pixel.
    assert_underrun_black_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready_o && !pix_valid_i) |=> pix_o == '0);

    // R9: the frame pulse lasts one cycle.
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    // R9: the frame pulse falls on a black pixel.
    assert_done_black_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> pix_o == '0);

endmodule

bind ntsc_raster_gen ntsc_raster_gen_chk #(.BPP(BPP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_n_o     (sync_n_o),
    .pix_o        (pix_o),
    .pix_ready_o  (pix_ready_o),
    .pix_valid_i  (pix_valid_i),
    .frame_done_o (frame_done_o)
);

// File: tb/ntsc_raster_gen_tb.sv
`timescale 1ns/1ps
module ntsc_raster_gen_tb;
    localparam int LINE_CYC = 64, HSYNC_CYC = 5, PIX_DIV = 2, PIX_PER_LINE = 16;
    localparam int WORD_W = 8, BPP = 2, FRAME_LINES = 12, VS_LINES = 2;
    localparam int VACT_START = 4, ACT_LINES = 6, PORCH_W = 8, BP_RST = 3;
    localparam int PPW = WORD_W / BPP;
    localparam int WIN = PIX_DIV * PIX_PER_LINE;
    localparam int MAXP = LINE_CYC - HSYNC_CYC - WIN - 1;
    localparam int FRAME_CYC = FRAME_LINES * LINE_CYC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PORCH_W-1:0] porch = PORCH_W'(BP_RST);
    logic pix_valid = 1'b0;
    logic [WORD_W-1:0] pix_word = '0;
    logic pix_ready, sync_n, frame_done;
    logic [BPP-1:0] pix;

    int checks = 0, errors = 0;
    bit run_chk = 0, finished = 0;
    int mode = 0, phase_cyc = 0, nonzero_cnt = 0;
    int dut_done_cnt = 0, mdl_done_cnt = 0;
    bit line_seen = 0;

    // Model state
    int mh, mv, mp, mdiv, mslot;
    logic [WORD_W-1:0] msh;
    logic [BPP-1:0] mpix;
    logic msync_n, mdone;

    always #2 clk = ~clk;

    ntsc_raster_gen #(
        .LINE_CYC(LINE_CYC), .HSYNC_CYC(HSYNC_CYC), .PIX_DIV(PIX_DIV),
        .PIX_PER_LINE(PIX_PER_LINE), .BPP(BPP), .WORD_W(WORD_W),
        .FRAME_LINES(FRAME_LINES), .VS_LINES(VS_LINES), .VACT_START(VACT_START),
        .ACT_LINES(ACT_LINES), .PORCH_W(PORCH_W), .BP_RST(BP_RST)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .porch_i(porch), .pix_valid_i(pix_valid),
        .pix_word_i(pix_word), .pix_ready_o(pix_ready), .sync_n_o(sync_n),
        .pix_o(pix), .frame_done_o(frame_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clampp(input int p);
        return (p > MAXP) ? MAXP : p;
    endfunction

    function automatic bit m_win();
        bit act;
        int hs;
        act = (mv >= VACT_START) && (mv < VACT_START + ACT_LINES);
        hs = HSYNC_CYC + mp;
        return act && (mh >= hs) && (mh < hs + WIN);
    endfunction

    // Reference timing model, advanced at each clock edge.
    always @(posedge clk) begin
        bit w, st, sy;
        if (!rst_n) begin
            mh = 0; mv = 0; mp = clampp(BP_RST); mdiv = 0; mslot = 0;
            msh = '0; mpix = '0; msync_n = 1'b1; mdone = 1'b0;
        end else begin
            w = m_win();
            st = w && (mdiv == 0);
            sy = (mv < VS_LINES) ? (mh < LINE_CYC - HSYNC_CYC) : (mh < HSYNC_CYC);
            msync_n = !sy;
            mdone = (mv == VACT_START + ACT_LINES - 1) && (mh == HSYNC_CYC + mp + WIN);
            if (!w) begin
                mpix = '0; msh = '0;
            end else if (st) begin
                if (mslot == 0) begin
                    if (pix_valid) begin
                        mpix = pix_word[WORD_W-1 -: BPP]; msh = pix_word << BPP;
                    end else begin
                        mpix = '0; msh = '0;
                    end
                end else begin
                    mpix = msh[WORD_W-1 -: BPP]; msh = msh << BPP;
                end
            end
            mdiv = !w ? 0 : ((mdiv == PIX_DIV - 1) ? 0 : mdiv + 1);
            mslot = !w ? 0 : (st ? ((mslot == PPW - 1) ? 0 : mslot + 1) : mslot);
            if (mh == LINE_CYC - 1) begin
                mp = clampp(int'(porch));
                mh = 0;
                mv = (mv == FRAME_LINES - 1) ? 0 : mv + 1;
            end else begin
                mh = mh + 1;
            end
        end
    end

    // Compare outputs away from the edge.
    always @(negedge clk) begin
        bit erdy;
        if (rst_n && run_chk) begin
            erdy = m_win() && (mdiv == 0) && (mslot == 0);
            chk(sync_n === msync_n, "R2 R3 sync level", int'(sync_n), int'(msync_n));
            chk(pix === mpix, "R6 R7 R8 pixel", int'(pix), int'(mpix));
            chk(pix_ready === erdy, "R5 ready", int'(pix_ready), int'(erdy));
            chk(frame_done === mdone, "R9 frame done", int'(frame_done), int'(mdone));
            if (mh == 0) line_seen = 0;
            if (pix_ready && !line_seen) begin
                line_seen = 1;
                chk(mh == HSYNC_CYC + mp, "R4 window start", mh, HSYNC_CYC + mp);
            end
            if (frame_done) dut_done_cnt++;
            if (mdone) mdl_done_cnt++;
            phase_cyc++;
            if (mode == 1 && phase_cyc > LINE_CYC && pix != '0) nonzero_cnt++;
        end
    end

    task automatic run_phase(input int md, input int p, input int ncyc);
        mode = md;
        phase_cyc = 0;
        porch = PORCH_W'(p);
        repeat (ncyc) begin
            @(negedge clk);
            case (md)
                1: begin pix_valid = 1'b0; pix_word = WORD_W'($urandom); end
                2: begin pix_valid = 1'b1; pix_word = 8'hE4; end
                default: begin
                    pix_valid = ($urandom % 10) < 8;
                    pix_word = WORD_W'($urandom);
                end
            endcase
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd9001);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sync_n === 1'b1, "R1 reset sync", int'(sync_n), 1);
        chk(pix === '0, "R1 reset pixel", int'(pix), 0);
        chk(frame_done === 1'b0, "R1 reset done", int'(frame_done), 0);
        chk(pix_ready === 1'b0, "R1 reset ready", int'(pix_ready), 0);
        rst_n = 1'b1;
        run_chk = 1;
        run_phase(0, 0, 2 * FRAME_CYC);
        run_phase(0, MAXP, FRAME_CYC);
        run_phase(0, MAXP + 9, FRAME_CYC);      // R4 clamp beyond limit
        run_phase(1, 7, 2 * FRAME_CYC);         // R7 underrun frames
        chk(nonzero_cnt == 0, "R7 underrun black", nonzero_cnt, 0);
        mode = 0;
        run_phase(2, 10, FRAME_CYC);            // R6 fixed pattern order
        for (int i = 0; i < 4; i++) begin
            run_phase(0, int'($urandom % (MAXP + 12)), FRAME_CYC);
        end
        chk(dut_done_cnt == mdl_done_cnt, "R9 done count", dut_done_cnt, mdl_done_cnt);
        chk(mdl_done_cnt >= 10, "R9 done per frame", mdl_done_cnt, 10);
        finished = 1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            finish_run();
        end
    end

endmodule